// File: doc/BRIEF.md
# Paging Protection Check Unit

This purely combinational unit decides whether one memory access passes two-level page protection. It takes the user/supervisor and read/write bits of a directory entry and of a table entry, plus their present bits. For a large page it takes only the directory entry. It also takes the privilege and kind of the current access, a write-protect control and a legacy-merge select. From these it produces an allow flag and the merged protection bits, which a translation cache can store. It also gives the low three bits of the fault code that a page fault would report.

Two merge rules are supported. In the normal rule, both merged bits are the AND of the two levels. In the legacy rule, the user bit is the OR of the two levels, and the write-protect control is treated as clear. The privilege decision comes from a 32-entry table that is computed at elaboration time. A parameter can replace the table with equivalent gate logic.

Top module: `page_prot_check`

## Requirements
- R1: With `legacy_mode`=0 and `large_page`=0, `comb_us` = `dir_us` AND `tbl_us`, and `comb_rw` = `dir_rw` AND `tbl_rw`.
- R2: With `legacy_mode`=1 and `large_page`=0, `comb_us` = `dir_us` OR `tbl_us`, and `comb_rw` = `dir_rw` AND `tbl_rw`.
- R3: With `large_page`=1, `comb_us` and `comb_rw` equal the directory bits. `tbl_us`, `tbl_rw` and `tbl_present` then have no effect on any output.
- R4: With effective write protect set, a present access is denied in two cases: a user access to a page with `comb_us`=0, and a write-type access to a page with `comb_rw`=0, at either privilege. Every other present access is allowed.
- R5: With effective write protect clear, every present supervisor access is allowed. A present user access is denied if `comb_us`=0, or if it is write-type and `comb_rw`=0.
- R6: Effective write protect is `wp_en` AND NOT `legacy_mode`, so `wp_en` has no effect in legacy mode.
- R7: `acc_op` encoding: 2'b00 read, 2'b01 write, 2'b10 read-modify-write, 2'b11 treated as write. Every code other than 2'b00 is write-type in all checks.
- R8: The access is present when `dir_present`=1 and either `large_page`=1 or `tbl_present`=1. A non-present access gives `allow`=0 and `fault_code[0]`=0. A present access gives `fault_code[0]`=1.
- R9: `fault_code[1]` is 1 for a write-type access, and `fault_code[2]` is 1 when `acc_user`=1, whatever the outcome.
- R10: Every output is identical for `USE_TABLE`=1 and `USE_TABLE`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dir_present | input | 1 | Directory entry present bit |
| dir_us | input | 1 | Directory entry user bit (1 = user page) |
| dir_rw | input | 1 | Directory entry write bit (1 = writable) |
| tbl_present | input | 1 | Table entry present bit |
| tbl_us | input | 1 | Table entry user bit |
| tbl_rw | input | 1 | Table entry write bit |
| large_page | input | 1 | Directory entry maps a large page directly |
| acc_user | input | 1 | Access made at user privilege |
| acc_op | input | 2 | Access kind, see R7 |
| wp_en | input | 1 | Write-protect control |
| legacy_mode | input | 1 | Select legacy merge rule |
| allow | output | 1 | Access permitted |
| comb_us | output | 1 | Merged user bit |
| comb_rw | output | 1 | Merged write bit |
| fault_code | output | 3 | Low fault code bits {user, write, protection} |

## Verification
The bench builds two copies of the unit side by side. One uses the default `USE_TABLE`=1, where the decision is read from the computed 32-entry table. The other uses `USE_TABLE`=0, where it comes from gate logic. Sweeping every one of the 4096 input combinations through both copies compares the two implementations against each other and against an independent model. That sweep reaches every merge rule, every page size, every present combination and every write-protect interaction.

// File: rtl/page_prot_check.sv
module page_prot_check #(
  parameter bit USE_TABLE = 1'b1,
  parameter int CODE_W    = 3
) (
  input  logic              dir_present,
  input  logic              dir_us,
  input  logic              dir_rw,
  input  logic              tbl_present,
  input  logic              tbl_us,
  input  logic              tbl_rw,
  input  logic              large_page,
  input  logic              acc_user,
  input  logic [1:0]        acc_op,
  input  logic              wp_en,
  input  logic              legacy_mode,
  output logic              allow,
  output logic              comb_us,
  output logic              comb_rw,
  output logic [CODE_W-1:0] fault_code
);

  localparam int IDX_W = 5;
  localparam int TBL_N = 1 << IDX_W;

  function automatic logic [TBL_N-1:0] build_tbl();
    logic [TBL_N-1:0] t;
    for (int i = 0; i < TBL_N; i++) begin
      logic wp, u, cu, cw, w;
      {wp, u, cu, cw, w} = IDX_W'(i);
      if (wp)
        t[i] = !(u && !cu) && !(w && !cw);
      else
        t[i] = !u || (cu && !(w && !cw));
    end
    return t;
  endfunction

  localparam logic [TBL_N-1:0] PRIV_TBL = build_tbl();

  logic is_write, eff_wp, present, priv_ok;
  logic [IDX_W-1:0] idx;

  assign is_write = |acc_op;
  assign eff_wp   = wp_en & ~legacy_mode;
  assign present  = dir_present & (large_page | tbl_present);

  assign comb_us = large_page  ? dir_us :
                   legacy_mode ? (dir_us | tbl_us) : (dir_us & tbl_us);
  assign comb_rw = large_page  ? dir_rw : (dir_rw & tbl_rw);

  assign idx = {eff_wp, acc_user, comb_us, comb_rw, is_write};

  generate
    if (USE_TABLE) begin : g_table
      assign priv_ok = PRIV_TBL[idx];
    end else begin : g_logic
      assign priv_ok = eff_wp ? (~(acc_user & ~comb_us) & ~(is_write & ~comb_rw))
                              : (~acc_user | (comb_us & ~(is_write & ~comb_rw)));
    end
  endgenerate

  assign allow      = present & priv_ok;
  assign fault_code = CODE_W'({acc_user, is_write, present});

  always_comb begin
    if (present && !acc_user && !(wp_en && !legacy_mode))
      a_r5_sup_free: assert (allow);
    if (acc_user && !comb_us)
      a_r4_user_sup_page: assert (!allow);
    if (wp_en && !legacy_mode && (acc_op != 2'b00) && !comb_rw)
      a_r4_wp_ro_write: assert (!allow);
    if (!dir_present)
      a_r8_absent: assert (!allow && !fault_code[0]);
    if (large_page)
      a_r3_large_dir: assert (comb_us == dir_us && comb_rw == dir_rw);
    if (legacy_mode && !large_page && (dir_us || tbl_us))
      a_r2_legacy_or: assert (comb_us);
  end

endmodule

// File: tb/tb_page_prot_check.sv
module tb_page_prot_check;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic dp, dus, drw, tp, tus, trw, lp, usr, wp, lg;
  logic [1:0] op;
  logic allow_a, cus_a, crw_a, allow_b, cus_b, crw_b;
  logic [2:0] fc_a, fc_b;

  page_prot_check #(.USE_TABLE(1'b1)) dut (
    .dir_present(dp), .dir_us(dus), .dir_rw(drw), .tbl_present(tp),
    .tbl_us(tus), .tbl_rw(trw), .large_page(lp), .acc_user(usr),
    .acc_op(op), .wp_en(wp), .legacy_mode(lg),
    .allow(allow_a), .comb_us(cus_a), .comb_rw(crw_a), .fault_code(fc_a));

  page_prot_check #(.USE_TABLE(1'b0)) dut_logic (
    .dir_present(dp), .dir_us(dus), .dir_rw(drw), .tbl_present(tp),
    .tbl_us(tus), .tbl_rw(trw), .large_page(lp), .acc_user(usr),
    .acc_op(op), .wp_en(wp), .legacy_mode(lg),
    .allow(allow_b), .comb_us(cus_b), .comb_rw(crw_b), .fault_code(fc_b));

  int total = 0;
  int bad = 0;

  // stimulus {lg,wp,lp,dp,tp,dus,drw,tus,trw,usr,op[1:0]}, expected {allow,cus,crw,fc[2:0]}
  localparam logic [17:0] VEC [12] = '{
    18'b0_0_0_1_1_1_1_1_0_1_00__1_1_0_101,
    18'b0_0_0_1_1_1_1_1_0_1_01__0_1_0_111,
    18'b0_0_0_1_1_1_1_0_1_0_01__1_0_1_011,
    18'b0_1_0_1_1_0_0_0_0_0_01__0_0_0_011,
    18'b0_0_0_1_1_0_0_0_0_0_01__1_0_0_011,
    18'b1_1_0_1_1_1_0_0_1_0_10__1_1_0_011,
    18'b1_0_0_1_1_0_1_1_1_1_00__1_1_1_101,
    18'b0_0_0_1_1_0_1_1_1_1_00__0_0_1_101,
    18'b0_0_1_1_0_1_1_0_0_1_01__1_1_1_111,
    18'b0_0_0_0_1_1_1_1_1_1_00__0_1_1_100,
    18'b0_0_0_1_0_1_1_1_1_0_11__0_1_1_010,
    18'b0_1_0_1_1_1_1_1_1_1_10__1_1_1_111
  };

  function automatic logic [5:0] model(input logic [11:0] s);
    logic l, w, p, d_p, t_p, d_u, d_w, t_u, t_w, u, cu, cw, wr, ew, pr, ok;
    logic [1:0] o;
    {l, w, p, d_p, t_p, d_u, d_w, t_u, t_w, u, o} = s;
    wr = (o != 2'b00);                        // R7
    ew = w && !l;                             // R6
    cu = p ? d_u : (l ? (d_u || t_u) : (d_u && t_u));  // R1 R2 R3
    cw = p ? d_w : (d_w && t_w);
    pr = d_p && (p || t_p);                   // R8
    if (ew) ok = !(u && !cu) && !(wr && !cw); // R4
    else    ok = !u || (cu && !(wr && !cw));  // R5
    return {pr && ok, cu, cw, u, wr, pr};     // R9
  endfunction

  task automatic apply(input logic [11:0] s);
    @(posedge clk);
    {lg, wp, lp, dp, tp, dus, drw, tus, trw, usr, op} = s;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    {lg, wp, lp, dp, tp, dus, drw, tus, trw, usr, op} = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 R9: idle inputs give a non-present read at supervisor level
    check("R8 idle", {allow_a, cus_a, crw_a, fc_a}, 6'b0_0_0_000);

    for (int i = 0; i < 12; i++) begin
      apply(VEC[i][17:6]);
      check($sformatf("R1-vector %0d (R2 R3 R4 R5 R6 R7)", i),
            {allow_a, cus_a, crw_a, fc_a}, VEC[i][5:0]);
    end

    // R10 and full model sweep
    for (int s = 0; s < 4096; s++) begin
      apply(12'(s));
      check("R10 table impl", {allow_a, cus_a, crw_a, fc_a}, model(12'(s)));
      check("R10 logic impl", {allow_b, cus_b, crw_b, fc_b}, model(12'(s)));
    end

    // R3: table bits and table present ignored for large pages
    apply(12'b0_0_1_1_0_1_0_1_1_1_00);
    check("R3 large ignore", {allow_a, cus_a, crw_a, fc_a}, 6'b1_1_0_101);
    apply(12'b0_0_1_1_1_1_0_0_0_1_00);
    check("R3 large ignore", {allow_a, cus_a, crw_a, fc_a}, 6'b1_1_0_101);
    // R6: legacy supervisor write to read-only page passes even with wp_en
    apply(12'b1_1_0_1_1_0_0_0_0_0_01);
    check("R6 legacy wp", {allow_a, cus_a, crw_a, fc_a}, 6'b1_0_0_011);
    // R7: code 2'b11 acts as write
    apply(12'b0_0_0_1_1_1_0_1_0_1_11);
    check("R7 op11", {allow_a, cus_a, crw_a, fc_a}, 6'b0_1_0_111);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule